// File: doc/BRIEF.md
# Prioritised Level-Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines for a single processor and delivers one interrupt request. Two register spaces sit behind one simple word-wide register port. The distributor space holds a global forwarding enable, per-line enable, pending and active state, and one priority byte per line. The processor space holds its own enable, a priority mask, the acknowledge and end-of-interrupt registers, the running priority and the active-priority state words.

Software reads the acknowledge register to claim the most urgent eligible interrupt. The claim makes that interrupt active and raises the running priority, so only strictly more urgent interrupts can preempt it. Writing its ID to the end-of-interrupt register releases it. Lower priority values are more urgent. Among equal priorities the lowest ID wins.

The register port takes `bus_cpu` = 0 for the distributor space and 1 for the processor space. Addresses are byte addresses and only word-aligned accesses act. Read data is registered and appears with `bus_rvalid` in the cycle after `bus_rd`.

Top module: `irq_hub`

## Requirements
- R1: In the distributor space, writes to the set banks at 0x100 (enable), 0x200 (pending) and 0x300 (active) set the bit of interrupt n, which lives in word n/32 at bit n%32, wherever the data bit is one. Zero data bits have no effect. Each bank reads back its current state at either its set or its clear address.
- R2: Writes to the clear banks at 0x180, 0x280 and 0x380 clear the bits whose data bit is one. Writing all ones clears the whole word, except that pending bits whose source line is still high are set again at once.
- R3: A high source line sets its pending bit, even while the line is disabled. The bit stays set after the line falls, until it is acknowledged or cleared.
- R4: The priority of interrupt n is the byte at distributor word 0x400 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)], and it reads back unchanged.
- R5: `irq_o` is registered and is high only when all of the following hold: distributor control (0x0) bit 0 is 1; processor control (0x0) bits [1:0] are nonzero; and an interrupt that is enabled, pending and not active has a priority numerically lower than both the mask at processor offset 0x4 and the running priority. It follows a state change within two clock cycles.
- R6: A read of processor offset 0xC returns, in bits [9:0] with all other bits zero, the ID of the qualifying interrupt with the lowest priority value. Ties go to the lowest ID. The value is 1023 when nothing qualifies.
- R7: A successful acknowledge sets the interrupt's active bit. It clears the pending bit unless the source line is high in that cycle. An active interrupt is neither signalled nor returned again until its end-of-interrupt.
- R8: Writing an ID to processor offset 0x10 clears that interrupt's active bit and releases its running-priority level. IDs that are out of range or not active are ignored.
- R9: The running priority reads at processor offset 0x14. It is 0xFF when nothing has been acknowledged; otherwise it is the most urgent acknowledged priority with bit 0 forced to zero. Only interrupts below it preempt.
- R10: Writing zero to processor offsets 0xD0, 0xD4, 0xD8 and 0xDC clears the running-priority state, so the running priority reads 0xFF. Active bits are not affected.
- R11: After synchronous reset, all state and control is zero, `irq_o` is low, the running priority is 0xFF and the acknowledge read returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_IRQ | Level-sensitive interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_cpu | input | 1 | Space select: 0 distributor, 1 processor |
| bus_addr | input | 12 | Byte address within the selected space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Two functions can fall in the same cycle: the acknowledge's pending clear and the source line's pending set. The bench holds a source line high through its acknowledge and checks that the pending bit survives and the interrupt returns after end-of-interrupt. It then drops the line and checks that the next acknowledge clears the bit. A second such meeting is the running-priority check against a newly pending interrupt of equal priority while another is active. The bench shows that equal priority stays silent and a more urgent one preempts. Expected IDs in the arbitration sweeps come from an arithmetic priority model in the bench.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int PRI_W = 8;
  localparam logic [9:0] SPURIOUS_ID = 10'd1023;

  // distributor bank codes taken from address bits [11:7]
  typedef enum logic [4:0] {
    BK_SET_EN   = 5'd2,
    BK_CLR_EN   = 5'd3,
    BK_SET_PEND = 5'd4,
    BK_CLR_PEND = 5'd5,
    BK_SET_ACT  = 5'd6,
    BK_CLR_ACT  = 5'd7
  } bank_e;

  localparam logic [11:0] ADR_CTRL = 12'h000;
  localparam logic [11:0] ADR_MASK = 12'h004;
  localparam logic [11:0] ADR_ACK  = 12'h00C;
  localparam logic [11:0] ADR_EOI  = 12'h010;
  localparam logic [11:0] ADR_RUN  = 12'h014;
  localparam logic [7:0]  ADR_APR_HI = 8'h0D;
endpackage

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int N_IRQ = 128,
  parameter int PW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_word,
  input  logic [31:0]       wr_data,
  output logic [N_IRQ*PW-1:0] pri_o
);
  localparam int NPW = N_IRQ / 4;
  localparam int AW  = $clog2(NPW);

  logic [31:0] mem_q [NPW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPW; i++) mem_q[i] <= 32'd0;
    end else if (wr_en && (int'(wr_word) < NPW)) begin
      mem_q[wr_word[AW-1:0]] <= wr_data;
    end
  end

  for (genvar w = 0; w < NPW; w++) begin : g_out
    assign pri_o[32*w +: 32] = mem_q[w];
  end
endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
  parameter int N   = 128,
  parameter int PW  = 8,
  parameter int IDW = 7
) (
  input  logic [N-1:0]    elig_i,
  input  logic [N*PW-1:0] pri_i,
  output logic            win_valid_o,
  output logic [IDW-1:0]  win_id_o,
  output logic [PW-1:0]   win_pri_o
);
  // heap-ordered tree, N a power of two; left subtree holds lower IDs
  localparam int NODES = 2 * N - 1;

  logic [NODES-1:0] v;
  logic [PW-1:0]    p [NODES];
  logic [IDW-1:0]   d [NODES];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign v[N-1+i] = elig_i[i];
    assign p[N-1+i] = pri_i[PW*i +: PW];
    assign d[N-1+i] = IDW'(i);
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_node
    logic take_l;
    assign take_l = v[2*k+1] && (!v[2*k+2] || (p[2*k+1] <= p[2*k+2]));
    assign v[k]   = v[2*k+1] | v[2*k+2];
    assign p[k]   = take_l ? p[2*k+1] : p[2*k+2];
    assign d[k]   = take_l ? d[2*k+1] : d[2*k+2];
  end

  assign win_valid_o = v[0];
  assign win_id_o    = d[0];
  assign win_pri_o   = p[0];
endmodule

// File: rtl/irq_hub_apr.sv
module irq_hub_apr #(
  parameter int PW = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_en,
  input  logic [PW-2:0]             set_lvl,
  input  logic                      clr_en,
  input  logic [PW-2:0]             clr_lvl,
  input  logic                      wr_en,
  input  logic [$clog2((2**(PW-1))/32)-1:0] wr_word,
  input  logic [31:0]               wr_data,
  output logic [(2**(PW-1))-1:0]    apr_o,
  output logic [PW-1:0]             run_pri_o
);
  localparam int LV = 2 ** (PW - 1);

  logic [LV-1:0] apr_q, apr_n;

  always_comb begin
    apr_n = apr_q;
    if (wr_en)  apr_n[32*wr_word +: 32] = wr_data;
    if (clr_en) apr_n[clr_lvl] = 1'b0;
    if (set_en) apr_n[set_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) apr_q <= '0;
    else     apr_q <= apr_n;
  end

  always_comb begin
    run_pri_o = '1;
    for (int i = LV - 1; i >= 0; i--) begin
      if (apr_q[i]) run_pri_o = PW'(2 * i);
    end
  end

  assign apr_o = apr_q;

  // R10: a zero write to state word 0 leaves it empty
  a_r10_apr_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en && (wr_word == '0) && (wr_data == 32'd0) && !set_en)
      |-> (apr_q[31:0] == 32'd0));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_IRQ = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] src_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_cpu,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  output logic             irq_o
);
  localparam int NW   = N_IRQ / 32;
  localparam int NPW  = N_IRQ / 4;
  localparam int IDW  = $clog2(N_IRQ);
  localparam int LV   = 2 ** (PRI_W - 1);
  localparam int AWW  = $clog2(LV / 32);

  // ---------------- decode ----------------
  logic aligned, dist_wr, cpu_wr, ack_rd, eoi_wr, prio_wr, apr_wr;
  logic [4:0] bank, bword;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign dist_wr = bus_wr && aligned && !bus_cpu;
  assign cpu_wr  = bus_wr && aligned && bus_cpu;
  assign ack_rd  = bus_rd && aligned && bus_cpu && (bus_addr == ADR_ACK);
  assign eoi_wr  = cpu_wr && (bus_addr == ADR_EOI);
  assign prio_wr = dist_wr && (bus_addr[11:10] == 2'b01);
  assign apr_wr  = cpu_wr && (bus_addr[11:4] == ADR_APR_HI);
  assign bank    = bus_addr[11:7];
  assign bword   = bus_addr[6:2];

  logic [N_IRQ-1:0] w_sen, w_cen, w_spd, w_cpd, w_sac, w_cac;

  for (genvar w = 0; w < NW; w++) begin : g_lane
    logic hit;
    assign hit = dist_wr && (bword == 5'(w));
    assign w_sen[32*w +: 32] = (hit && bank == BK_SET_EN)   ? bus_wdata : 32'd0;
    assign w_cen[32*w +: 32] = (hit && bank == BK_CLR_EN)   ? bus_wdata : 32'd0;
    assign w_spd[32*w +: 32] = (hit && bank == BK_SET_PEND) ? bus_wdata : 32'd0;
    assign w_cpd[32*w +: 32] = (hit && bank == BK_CLR_PEND) ? bus_wdata : 32'd0;
    assign w_sac[32*w +: 32] = (hit && bank == BK_SET_ACT)  ? bus_wdata : 32'd0;
    assign w_cac[32*w +: 32] = (hit && bank == BK_CLR_ACT)  ? bus_wdata : 32'd0;
  end

  // ---------------- control registers ----------------
  logic       dist_en_q;
  logic [1:0] cpu_en_q;
  logic [7:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_en_q <= 1'b0;
      cpu_en_q  <= 2'b00;
      mask_q    <= 8'h00;
    end else begin
      if (dist_wr && bus_addr == ADR_CTRL) dist_en_q <= bus_wdata[0];
      if (cpu_wr && bus_addr == ADR_CTRL)  cpu_en_q  <= bus_wdata[1:0];
      if (cpu_wr && bus_addr == ADR_MASK)  mask_q    <= bus_wdata[7:0];
    end
  end

  // ---------------- priorities and arbitration ----------------
  logic [N_IRQ*PRI_W-1:0] pri_flat;

  irq_hub_prio #(.N_IRQ(N_IRQ), .PW(PRI_W)) prio_i (
    .clk(clk), .rst(rst), .wr_en(prio_wr), .wr_word(bus_addr[9:2]),
    .wr_data(bus_wdata), .pri_o(pri_flat)
  );

  logic [N_IRQ-1:0] en_q, pend_q, act_q, elig;
  logic             arb_valid;
  logic [IDW-1:0]   arb_id;
  logic [PRI_W-1:0] arb_pri;

  assign elig = en_q & pend_q & ~act_q;

  irq_hub_arb #(.N(N_IRQ), .PW(PRI_W), .IDW(IDW)) arb_i (
    .elig_i(elig), .pri_i(pri_flat),
    .win_valid_o(arb_valid), .win_id_o(arb_id), .win_pri_o(arb_pri)
  );

  // ---------------- running priority ----------------
  logic [PRI_W-1:0] run_pri;
  logic [LV-1:0]    apr_flat;
  logic             best_valid_q;
  logic [IDW-1:0]   best_id_q;
  logic [PRI_W-1:0] best_pri_q;
  logic             ack_hit, eoi_ok;
  logic [9:0]       eoi_id;
  logic [IDW-1:0]   eoi_idx;

  assign eoi_id  = bus_wdata[9:0];
  assign eoi_idx = eoi_id[IDW-1:0];
  assign eoi_ok  = eoi_wr && (int'(eoi_id) < N_IRQ) && act_q[eoi_idx];

  irq_hub_apr #(.PW(PRI_W)) apr_i (
    .clk(clk), .rst(rst),
    .set_en(ack_hit), .set_lvl(best_pri_q[PRI_W-1:1]),
    .clr_en(eoi_ok), .clr_lvl(pri_flat[PRI_W*eoi_idx+1 +: PRI_W-1]),
    .wr_en(apr_wr), .wr_word(bus_addr[AWW+1:2]), .wr_data(bus_wdata),
    .apr_o(apr_flat), .run_pri_o(run_pri)
  );

  logic gates_on, sig_ok;
  assign gates_on = dist_en_q && (cpu_en_q != 2'b00);
  assign sig_ok   = gates_on && arb_valid && (arb_pri < mask_q) && (arb_pri < run_pri);
  assign ack_hit  = ack_rd && best_valid_q && elig[best_id_q] && gates_on &&
                    (best_pri_q < mask_q) && (best_pri_q < run_pri);

  logic [N_IRQ-1:0] ack_vec, eoi_vec;
  assign ack_vec = {{(N_IRQ-1){1'b0}}, ack_hit} << best_id_q;
  assign eoi_vec = {{(N_IRQ-1){1'b0}}, eoi_ok} << eoi_idx;

  // ---------------- per-interrupt state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      en_q   <= (en_q & ~w_cen) | w_sen;
      pend_q <= (pend_q & ~w_cpd & ~ack_vec) | w_spd | src_i;
      act_q  <= (act_q & ~w_cac & ~eoi_vec) | w_sac | ack_vec;
    end
  end

  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      best_valid_q <= 1'b0;
      best_id_q    <= '0;
      best_pri_q   <= '1;
      irq_q        <= 1'b0;
    end else begin
      best_valid_q <= arb_valid;
      best_id_q    <= arb_id;
      best_pri_q   <= arb_pri;
      irq_q        <= sig_ok;
    end
  end
  assign irq_o = irq_q;

  // ---------------- read path ----------------
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'd0;
    if (!bus_cpu) begin
      if (bus_addr == ADR_CTRL) begin
        rd_mux = {31'd0, dist_en_q};
      end else if (bus_addr[11:10] == 2'b01) begin
        for (int p = 0; p < NPW; p++)
          if (bus_addr[9:2] == 8'(p)) rd_mux = pri_flat[32*p +: 32];
      end else begin
        for (int w = 0; w < NW; w++) begin
          if (bword == 5'(w)) begin
            case (bank)
              BK_SET_EN,   BK_CLR_EN:   rd_mux = en_q[32*w +: 32];
              BK_SET_PEND, BK_CLR_PEND: rd_mux = pend_q[32*w +: 32];
              BK_SET_ACT,  BK_CLR_ACT:  rd_mux = act_q[32*w +: 32];
              default:                  rd_mux = 32'd0;
            endcase
          end
        end
      end
    end else begin
      if (bus_addr == ADR_CTRL)      rd_mux = {30'd0, cpu_en_q};
      else if (bus_addr == ADR_MASK) rd_mux = {24'd0, mask_q};
      else if (bus_addr == ADR_ACK)  rd_mux = ack_hit ? 32'(best_id_q) : 32'(SPURIOUS_ID);
      else if (bus_addr == ADR_RUN)  rd_mux = {24'd0, run_pri};
      else if (bus_addr[11:4] == ADR_APR_HI) rd_mux = apr_flat[32*bus_addr[AWW+1:2] +: 32];
    end
  end

  logic [31:0] rdata_q;
  logic        rvalid_q, ack_rd_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= 32'd0;
      rvalid_q <= 1'b0;
      ack_rd_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd && aligned;
      ack_rd_q <= ack_rd;
      if (bus_rd && aligned) rdata_q <= rd_mux;
    end
  end
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // ---------------- assertions ----------------
  // R5: a request needs both enables in the cycle it was formed
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(dist_en_q && (cpu_en_q != 2'b00)));

  // R6: acknowledge returns an in-range ID or the spurious value only
  a_r6_ack_range: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && ack_rd_q) |->
      ((bus_rdata[31:10] == 22'd0) &&
       ((bus_rdata[9:0] == SPURIOUS_ID) || (int'(bus_rdata[9:0]) < N_IRQ))));

  // R7: a returned ID is marked active
  a_r7_ack_marks_active: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && ack_rd_q && (bus_rdata[9:0] != SPURIOUS_ID)) |->
      act_q[bus_rdata[IDW-1:0]]);

  // R2: clearing all of pending word 0 leaves only live source lines
  a_r2_clear_all_word0: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && (w_cpd[31:0] == 32'hFFFF_FFFF)) |->
      (pend_q[31:0] == $past(src_i[31:0])));

  // R8: end-of-interrupt deactivates its ID
  a_r8_eoi_deactivates: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && eoi_ok && !ack_hit && (w_sac == '0)) |->
      !act_q[$past(eoi_idx)]);
endmodule

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_cpu = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_hub #(.N_IRQ(N)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_o(irq)
  );

  function automatic logic [7:0] pri_of(int n);
    return 8'(((n * 7) % 32) + 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_cpu = cpu; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(output logic [31:0] d);
    rd(1'b1, 12'h00C, d);
    idle(2);
  endtask

  task automatic clear_pending();
    wr(1'b0, 12'h280, 32'hFFFF_FFFF);
    wr(1'b0, 12'h284, 32'hFFFF_FFFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] pm;
    int exp_id;
    int best_p;

    idle(4);
    rst = 1'b0;
    idle(2);

    // R11 reset state
    check("R11 irq after reset", {31'd0, irq}, 32'd0);
    rd(1'b1, 12'h00C, d); check("R11 ack after reset", d, 32'd1023);
    rd(1'b1, 12'h014, d); check("R11 running priority", d, 32'h0000_00FF);
    rd(1'b0, 12'h100, d); check("R11 enable word", d, 32'd0);
    rd(1'b0, 12'h000, d); check("R11 dist ctrl", d, 32'd0);
    rd(1'b1, 12'h004, d); check("R11 mask", d, 32'd0);

    // R1 set banks, zero-bit no effect, readback at clear address
    wr(1'b0, 12'h100, 32'h0000_00F0);
    rd(1'b0, 12'h100, d); check("R1 set enable", d, 32'h0000_00F0);
    wr(1'b0, 12'h100, 32'h0000_0000);
    rd(1'b0, 12'h100, d); check("R1 zero write no effect", d, 32'h0000_00F0);
    wr(1'b0, 12'h100, 32'h0000_000F);
    rd(1'b0, 12'h180, d); check("R1 readback at clear addr", d, 32'h0000_00FF);
    wr(1'b0, 12'h104, 32'h8000_0001);
    rd(1'b0, 12'h104, d); check("R1 word1 set", d, 32'h8000_0001);
    wr(1'b0, 12'h300, 32'h0000_0A00);
    rd(1'b0, 12'h380, d); check("R1 set active", d, 32'h0000_0A00);

    // R2 clear banks
    wr(1'b0, 12'h180, 32'h0000_0030);
    rd(1'b0, 12'h100, d); check("R2 clear enable bits", d, 32'h0000_00CF);
    wr(1'b0, 12'h180, 32'hFFFF_FFFF);
    wr(1'b0, 12'h184, 32'hFFFF_FFFF);
    rd(1'b0, 12'h100, d); check("R2 clear all enable w0", d, 32'd0);
    rd(1'b0, 12'h104, d); check("R2 clear all enable w1", d, 32'd0);
    wr(1'b0, 12'h380, 32'hFFFF_FFFF);
    rd(1'b0, 12'h300, d); check("R2 clear all active", d, 32'd0);
    wr(1'b0, 12'h200, 32'h0000_0F00);
    @(negedge clk); src[2] = 1'b1;
    clear_pending();
    rd(1'b0, 12'h200, d); check("R2 clear all keeps live source", d, 32'h0000_0004);
    @(negedge clk); src[2] = 1'b0;
    clear_pending();
    rd(1'b0, 12'h200, d); check("R2 pending empty", d, 32'd0);

    // R3 level source latches pending while disabled
    @(negedge clk); src[37] = 1'b1;
    @(negedge clk); src[37] = 1'b0;
    idle(2);
    rd(1'b0, 12'h204, d); check("R3 pending held after line drop", d, 32'h0000_0020);
    wr(1'b0, 12'h284, 32'h0000_0020);
    rd(1'b0, 12'h204, d); check("R3 pending cleared", d, 32'd0);

    // R4 priority bytes
    for (int w = 0; w < N / 4; w++)
      wr(1'b0, 12'(12'h400 + 4 * w),
         {pri_of(4*w+3), pri_of(4*w+2), pri_of(4*w+1), pri_of(4*w)});
    for (int w = 0; w < N / 4; w++) begin
      rd(1'b0, 12'(12'h400 + 4 * w), d);
      check("R4 priority word", d,
            {pri_of(4*w+3), pri_of(4*w+2), pri_of(4*w+1), pri_of(4*w)});
    end

    // enable everything
    wr(1'b0, 12'h100, 32'hFFFF_FFFF);
    wr(1'b0, 12'h104, 32'hFFFF_FFFF);
    wr(1'b0, 12'h000, 32'd1);
    wr(1'b1, 12'h000, 32'd3);
    wr(1'b1, 12'h004, 32'h0000_00FF);

    // R6 arbitration sweep: single IDs then mixed patterns
    for (int k = 0; k < 2 * N; k++) begin
      if (k < N) pm = 64'd1 << k;
      else if (k == N) pm = 64'd0;
      else pm = {32'(k * 32'h85EB_CA6B), 32'(k * 32'h9E37_79B1)};
      clear_pending();
      wr(1'b0, 12'h200, pm[31:0]);
      wr(1'b0, 12'h204, pm[63:32]);
      idle(3);
      exp_id = 1023; best_p = 256;
      for (int n = 0; n < N; n++)
        if (pm[n] && int'(pri_of(n)) < best_p) begin
          best_p = int'(pri_of(n)); exp_id = n;
        end
      check("R5 irq follows pending", {31'd0, irq}, {31'd0, exp_id != 1023});
      ack(d);
      check("R6 ack winner", d, 32'(exp_id));
      if (exp_id != 1023) begin
        rd(1'b1, 12'h014, d);
        check("R9 running priority", d, 32'(best_p & 8'hFE));
        wr(1'b1, 12'h010, 32'(exp_id));
        rd(1'b1, 12'h014, d);
        check("R8 running priority released", d, 32'h0000_00FF);
      end
    end
    clear_pending();
    rd(1'b0, 12'h300, d); check("R8 active word0 empty", d, 32'd0);
    rd(1'b0, 12'h304, d); check("R8 active word1 empty", d, 32'd0);

    // R5 mask and enables; id 3 priority 0x1D
    wr(1'b0, 12'h200, 32'h0000_0008);
    wr(1'b1, 12'h004, 32'h0000_001D);
    idle(3);
    check("R5 mask equal blocks", {31'd0, irq}, 32'd0);
    ack(d); check("R5 masked ack spurious", d, 32'd1023);
    wr(1'b1, 12'h004, 32'h0000_001E);
    idle(3);
    check("R5 mask above admits", {31'd0, irq}, 32'd1);
    wr(1'b0, 12'h000, 32'd0);
    idle(3);
    check("R5 dist disable", {31'd0, irq}, 32'd0);
    wr(1'b0, 12'h000, 32'd1);
    wr(1'b1, 12'h000, 32'd0);
    idle(3);
    check("R5 cpu disable", {31'd0, irq}, 32'd0);
    ack(d); check("R5 cpu disabled ack spurious", d, 32'd1023);
    wr(1'b1, 12'h000, 32'd2);
    idle(3);
    check("R5 one group bit enables", {31'd0, irq}, 32'd1);
    wr(1'b1, 12'h004, 32'h0000_00FF);
    clear_pending();

    // R7 acknowledge against a live source line (id 9)
    @(negedge clk); src[9] = 1'b1;
    idle(3);
    check("R7 irq from source", {31'd0, irq}, 32'd1);
    ack(d); check("R7 ack id", d, 32'd9);
    rd(1'b0, 12'h200, d); check("R7 pending kept with line high", d & 32'h200, 32'h200);
    rd(1'b0, 12'h300, d); check("R7 active set", d, 32'h0000_0200);
    idle(2);
    check("R7 active not signalled", {31'd0, irq}, 32'd0);
    ack(d); check("R7 active not returned", d, 32'd1023);
    wr(1'b1, 12'h010, 32'd9);
    idle(3);
    check("R7 resignalled after eoi", {31'd0, irq}, 32'd1);
    @(negedge clk); src[9] = 1'b0;
    idle(2);
    ack(d); check("R7 second ack", d, 32'd9);
    rd(1'b0, 12'h200, d); check("R7 pending cleared with line low", d, 32'd0);
    wr(1'b1, 12'h010, 32'd9);

    // R9 preemption: id1 pri 15, id33 pri 15, id0 pri 8
    clear_pending();
    wr(1'b0, 12'h200, 32'h0000_0002);
    idle(3);
    ack(d); check("R9 ack id1", d, 32'd1);
    rd(1'b1, 12'h014, d); check("R9 running priority 0x0E", d, 32'h0000_000E);
    wr(1'b0, 12'h204, 32'h0000_0002);
    idle(3);
    check("R9 equal priority no preempt", {31'd0, irq}, 32'd0);
    ack(d); check("R9 equal priority ack spurious", d, 32'd1023);
    wr(1'b0, 12'h200, 32'h0000_0001);
    idle(3);
    check("R9 urgent preempts", {31'd0, irq}, 32'd1);
    ack(d); check("R9 ack id0", d, 32'd0);
    rd(1'b1, 12'h014, d); check("R9 running priority 0x08", d, 32'h0000_0008);
    wr(1'b1, 12'h010, 32'd0);
    rd(1'b1, 12'h014, d); check("R8 back to outer level", d, 32'h0000_000E);

    // R8 ignored end-of-interrupt writes
    wr(1'b1, 12'h010, 32'd70);
    rd(1'b0, 12'h300, d); check("R8 out-of-range id ignored", d, 32'h0000_0002);
    wr(1'b1, 12'h010, 32'd2);
    rd(1'b0, 12'h300, d); check("R8 inactive id ignored", d, 32'h0000_0002);
    rd(1'b1, 12'h014, d); check("R8 level unchanged", d, 32'h0000_000E);
    wr(1'b1, 12'h010, 32'd1);
    rd(1'b1, 12'h014, d); check("R8 idle level", d, 32'h0000_00FF);
    idle(2);
    check("R9 waiting equal now signalled", {31'd0, irq}, 32'd1);
    clear_pending();

    // R10 zero writes clear running-priority state, active kept
    wr(1'b0, 12'h200, 32'h0000_0002);
    idle(3);
    ack(d); check("R10 ack id1", d, 32'd1);
    rd(1'b1, 12'h0D0, d); check("R10 state word set", d, 32'h0000_0080);
    wr(1'b1, 12'h0D0, 32'd0);
    wr(1'b1, 12'h0D4, 32'd0);
    wr(1'b1, 12'h0D8, 32'd0);
    wr(1'b1, 12'h0DC, 32'd0);
    rd(1'b1, 12'h014, d); check("R10 running priority cleared", d, 32'h0000_00FF);
    rd(1'b0, 12'h300, d); check("R10 active untouched", d, 32'h0000_0002);
    wr(1'b1, 12'h010, 32'd1);
    rd(1'b0, 12'h300, d); check("R8 final active clear", d, 32'd0);

    finish_run();
  end
endmodule